// File: doc/BRIEF.md
# Prescaled Auto-Reload Interval Timer

This block is an 8-bit down-counting timer that runs entirely from its own timer clock, separate from any bus clock. A programmable prescaler divides the timer clock and emits count pulses. Each count pulse lowers a main counter by one. When a count pulse arrives while the counter holds 01 hex, the counter reloads from a data register and the block produces a timeout. Each timeout flips a timer output line and, when enabled, raises a one-cycle interrupt strobe. A data value of 00 gives the full 256-pulse interval.

A mode bit selects pulse-width measurement instead of plain delay. In that mode the prescaler advances only while a synchronized auxiliary input sits at its active level. When that input returns to its idle level, a separate auxiliary interrupt strobe fires, so software can read the remaining count and work out the pulse length. Software programs the block through a small write port with two targets, control and data. The live counter value is always visible on an output.

Top module: `presc_reload_timer`

## Requirements
- R1: After reset the counter reads 0, the timer output is low, both interrupt strobes are low and the timer is stopped.
- R2: A write with wrSel=0 loads the control register: bits [2:0] choose the prescale (0 stops, 1..7 divide by 4, 10, 16, 50, 64, 100, 200), bit 3 selects pulse-width mode when 1, bit 4 enables the timeout strobe and bit 5 enables the auxiliary strobe. With prescale 0 the counter holds its value.
- R3: A control write restarts the prescaler. The first count pulse lands on the D-th timer clock edge after the write edge, where D is the divisor, and later pulses follow every D edges. Each count pulse lowers the counter by one.
- R4: A count pulse that finds the counter at 01 reloads it from the data register. In that case tmoIrq is high for exactly the one cycle after that edge, provided bit 4 is set.
- R5: timerOut toggles on every timeout and otherwise holds, whether or not the strobe is enabled. With divide-by-10 and data 100 it toggles every 1000 timer clocks.
- R6: Data value 00 produces a timeout every 256 count pulses, and the counter reads FF after the first pulse.
- R7: A write with wrSel=1 stores the data register. If the timer is stopped, the same write also loads the counter. If it is running, the counter is untouched and the new value takes effect at the next reload.
- R8: In pulse-width mode the prescaler advances only on edges where the two-flop-synchronized auxiliary input is active. A pulse that is active for L timer clocks advances it L times.
- R9: In pulse-width mode with bit 5 set, an active-to-idle transition of the auxiliary input raises auxIrq for one cycle, on the third edge after the input changes. In delay mode auxIrq stays low.
- R10: With bit 4 clear, timeouts still reload the counter and toggle the output, but tmoIrq stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 control, 1 data |
| wrData | input | 8 | Write value |
| auxIn | input | 1 | Asynchronous auxiliary gate input |
| timerOut | output | 1 | Output that toggles on each timeout |
| tmoIrq | output | 1 | One-cycle timeout interrupt strobe |
| auxIrq | output | 1 | One-cycle auxiliary end-of-pulse strobe |
| count | output | 8 | Current main counter value |

## Verification
The assertions assume that the write port is synchronous to the timer clock. They also assume that auxIn may change at any time but is only used after the synchronizer, so the gate and edge checks refer to the synchronized level. The stimulus issues writes at the falling clock edge for one cycle. It changes the prescale only through a control write, which restarts the prescaler, and it holds each auxiliary level for many cycles, so pulse widths and strobe timing can be predicted exactly.

// File: rtl/prt_pkg.sv
package prt_pkg;

  localparam int CTRL_W   = 6;
  localparam int F_SEL_LO = 0;
  localparam int F_SEL_HI = 2;
  localparam int F_MODE   = 3;
  localparam int F_TMO_EN = 4;
  localparam int F_AUX_EN = 5;

  typedef struct packed {
    logic countPulse;
    logic dataWrite;
    logic stopLoad;
    logic tmoEnable;
  } tmrStrobe_t;

  function automatic int unsigned divFor(logic [2:0] sel);
    case (sel)
      3'd1:    divFor = 4;
      3'd2:    divFor = 10;
      3'd3:    divFor = 16;
      3'd4:    divFor = 50;
      3'd5:    divFor = 64;
      3'd6:    divFor = 100;
      3'd7:    divFor = 200;
      default: divFor = 0;
    endcase
  endfunction

endpackage

// File: rtl/prt_ctrl.sv
module prt_ctrl #(
  parameter int PRESC_W = 8,
  parameter bit AUX_ACTIVE_HIGH = 1'b1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic                         wrSel,
  input  logic [prt_pkg::CTRL_W-1:0]   ctrlBits,
  input  logic                         auxIn,
  output prt_pkg::tmrStrobe_t          strb,
  output logic                         auxIrq
);
  import prt_pkg::*;

  localparam logic AUX_IDLE = ~AUX_ACTIVE_HIGH;

  logic [CTRL_W-1:0]  ctrlReg;
  logic [PRESC_W-1:0] presCnt;
  logic [PRESC_W-1:0] divMinus1;
  logic [2:0]         presSel;
  logic               modePw, auxIrqEn;
  logic               auxSync1, auxSync2, auxAct, auxActPrev;
  logic               ctrlWrite, running, advance, pulse;

  assign presSel   = ctrlReg[F_SEL_HI:F_SEL_LO];
  assign modePw    = ctrlReg[F_MODE];
  assign auxIrqEn  = ctrlReg[F_AUX_EN];
  assign ctrlWrite = wrEn && !wrSel;
  assign running   = (presSel != 3'd0);
  assign divMinus1 = PRESC_W'(divFor(presSel) - 1);
  assign auxAct    = (auxSync2 == AUX_ACTIVE_HIGH);
  assign advance   = running && (!modePw || auxAct);
  assign pulse     = advance && !ctrlWrite && (presCnt == divMinus1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      auxSync1   <= AUX_IDLE;
      auxSync2   <= AUX_IDLE;
      auxActPrev <= 1'b0;
      presCnt    <= '0;
      auxIrq     <= 1'b0;
    end else begin
      auxSync1   <= auxIn;
      auxSync2   <= auxSync1;
      auxActPrev <= auxAct;
      auxIrq     <= modePw && auxIrqEn && auxActPrev && !auxAct;
      if (ctrlWrite) begin
        ctrlReg <= ctrlBits;
        presCnt <= '0;
      end else if (advance) begin
        presCnt <= (presCnt == divMinus1) ? '0 : presCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.countPulse = pulse;
    strb.dataWrite  = wrEn && wrSel;
    strb.stopLoad   = wrEn && wrSel && !running;
    strb.tmoEnable  = ctrlReg[F_TMO_EN];
  end

  AST_STOP_NO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (presSel == 3'd0) |-> !strb.countPulse); // R2
  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    (modePw && !auxAct) |-> !strb.countPulse); // R8
  AST_AUX_ONLY_PW: assert property (@(posedge clk) disable iff (!rstN)
    auxIrq |-> $past(modePw)); // R9
  AST_AUX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    auxIrq |=> !auxIrq); // R9

endmodule

// File: rtl/prt_datapath.sv
module prt_datapath #(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DATA_W-1:0]    wrData,
  input  prt_pkg::tmrStrobe_t  strb,
  output logic [DATA_W-1:0]    count,
  output logic                 timerOut,
  output logic                 tmoIrq
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] mainCnt;
  logic              wrap;

  assign wrap  = strb.countPulse && (mainCnt == ONE) && !strb.stopLoad;
  assign count = mainCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg  <= '0;
      mainCnt  <= '0;
      timerOut <= 1'b0;
      tmoIrq   <= 1'b0;
    end else begin
      if (strb.dataWrite) dataReg <= wrData;
      if (strb.stopLoad)        mainCnt <= wrData;
      else if (wrap)            mainCnt <= dataReg;
      else if (strb.countPulse) mainCnt <= mainCnt - 1'b1;
      timerOut <= timerOut ^ wrap;
      tmoIrq   <= wrap && strb.tmoEnable;
    end
  end

  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countPulse && mainCnt != ONE) |=> (mainCnt == $past(mainCnt) - 1'b1)); // R3
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countPulse && mainCnt == ONE) |=> (mainCnt == $past(dataReg))); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.countPulse && !strb.stopLoad) |=> $stable(mainCnt)); // R2
  AST_TOGGLE_ON_TMO: assert property (@(posedge clk) disable iff (!rstN)
    (timerOut != $past(timerOut)) |-> $past(strb.countPulse && mainCnt == ONE)); // R5
  AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    tmoIrq |-> $past(strb.tmoEnable)); // R10

endmodule

// File: rtl/presc_reload_timer.sv
module presc_reload_timer #(
  parameter int DATA_W = 8,
  parameter int PRESC_W = 8,
  parameter bit AUX_ACTIVE_HIGH = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              auxIn,
  output logic              timerOut,
  output logic              tmoIrq,
  output logic              auxIrq,
  output logic [DATA_W-1:0] count
);
  prt_pkg::tmrStrobe_t strb;

  prt_ctrl #(.PRESC_W(PRESC_W), .AUX_ACTIVE_HIGH(AUX_ACTIVE_HIGH)) ctrlUnit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .ctrlBits(wrData[prt_pkg::CTRL_W-1:0]), .auxIn(auxIn),
    .strb(strb), .auxIrq(auxIrq)
  );

  prt_datapath #(.DATA_W(DATA_W)) dataUnit (
    .clk(clk), .rstN(rstN), .wrData(wrData), .strb(strb),
    .count(count), .timerOut(timerOut), .tmoIrq(tmoIrq)
  );

endmodule

// File: tb/presc_reload_timer_test.sv
`timescale 1ns/1ps
module presc_reload_timer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, wrSel = 1'b0, auxIn = 1'b0;
  logic [7:0] wrData = '0;
  logic timerOut, tmoIrq, auxIrq;
  logic [7:0] count;

  int cyc = 0, checks = 0, fails = 0, auxSeen = 0, expV;
  int tmoQ[$];
  int auxQ[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  presc_reload_timer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .auxIn(auxIn), .timerOut(timerOut), .tmoIrq(tmoIrq), .auxIrq(auxIrq),
    .count(count)
  );

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Scoreboard monitor: strobes are compared against queued expected cycles
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (tmoIrq) begin
        if (tmoQ.size() == 0) check("R4", cyc, -1, "unexpected tmoIrq");
        else begin expV = tmoQ.pop_front(); check("R4", cyc, expV, "tmoIrq cycle"); end
      end
      if (auxIrq) begin
        auxSeen++;
        if (auxQ.size() == 0) check("R9", cyc, -1, "unexpected auxIrq");
        else begin expV = auxQ.pop_front(); check("R9", cyc, expV, "auxIrq cycle"); end
      end
    end
  end

  task automatic writeReg(input logic sel, input logic [7:0] val, output int w);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
    w = cyc;
  endtask

  task automatic waitCyc(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic setAux(logic v, output int k);
    @(negedge clk);
    auxIn = v;
    k = cyc;
  endtask

  initial begin
    #(8ns * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int w, k, j, s, auxBefore;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1", count, 0, "count");
    check("R1", timerOut, 0, "timerOut");
    check("R1", tmoIrq, 0, "tmoIrq");
    check("R1", auxIrq, 0, "auxIrq");

    // R7 stopped data write loads counter; R3/R4 divide-by-4, data 5
    writeReg(1'b1, 8'd5, w);
    check("R7", count, 5, "stopped load");
    writeReg(1'b0, 8'h11, w);
    tmoQ.push_back(w + 20);
    tmoQ.push_back(w + 40);
    waitCyc(w + 7);  check("R3", count, 4, "before second pulse");
    waitCyc(w + 8);  check("R3", count, 3, "after two pulses");
    waitCyc(w + 20); check("R5", timerOut, 1, "first toggle");
    check("R4", count, 5, "reload value");
    waitCyc(w + 40); check("R5", timerOut, 0, "second toggle");
    waitCyc(w + 44);
    writeReg(1'b0, 8'h00, s);
    waitCyc(s + 30); check("R2", count, 4, "stopped counter holds");

    // R7 running data write does not touch the counter
    writeReg(1'b1, 8'd3, w);
    check("R7", count, 3, "stopped load 3");
    writeReg(1'b0, 8'h11, w);
    tmoQ.push_back(w + 12);
    tmoQ.push_back(w + 40);
    waitCyc(w + 5);
    writeReg(1'b1, 8'd7, k);
    check("R7", count, 2, "running write ignored by counter");
    waitCyc(w + 13); check("R7", count, 7, "new data used at reload");
    waitCyc(w + 42);
    writeReg(1'b0, 8'h00, s);

    // R5/R10 divide-by-10, data 100, strobe disabled
    writeReg(1'b1, 8'd100, w);
    writeReg(1'b0, 8'h02, w);
    waitCyc(w + 999);  check("R5", timerOut, 0, "before 1000 clocks");
    waitCyc(w + 1000); check("R5", timerOut, 1, "toggle at 1000");
    check("R10", tmoIrq, 0, "strobe suppressed");
    check("R10", count, 100, "reload while suppressed");
    waitCyc(w + 1999); check("R5", timerOut, 1, "hold until 2000");
    waitCyc(w + 2000); check("R5", timerOut, 0, "toggle at 2000");
    waitCyc(w + 2005);
    writeReg(1'b0, 8'h00, s);

    // R6 data 00 means 256 pulses
    writeReg(1'b1, 8'd0, w);
    writeReg(1'b0, 8'h11, w);
    tmoQ.push_back(w + 1024);
    waitCyc(w + 4);    check("R6", count, 255, "first pulse from 00");
    waitCyc(w + 1023); check("R6", timerOut, 0, "no early timeout");
    waitCyc(w + 1024); check("R6", timerOut, 1, "timeout after 256 pulses");
    waitCyc(w + 1030);
    writeReg(1'b0, 8'h00, s);

    // R8/R9 pulse-width mode, divide-by-4, aux strobe enabled
    writeReg(1'b1, 8'd200, w);
    writeReg(1'b0, 8'h29, w);
    waitCyc(w + 20); check("R8", count, 200, "gate closed while aux idle");
    setAux(1'b1, k);
    waitCyc(k + 40);
    setAux(1'b0, j);
    auxQ.push_back(j + 3);
    waitCyc(j + 4); check("R8", count, 190, "41-cycle pulse");
    setAux(1'b1, k);
    waitCyc(k + 19);
    setAux(1'b0, j);
    auxQ.push_back(j + 3);
    waitCyc(j + 10); check("R8", count, 185, "20-cycle pulse with carry");

    // R9 delay mode: aux edges ignored
    writeReg(1'b0, 8'h20, w);
    auxBefore = auxSeen;
    setAux(1'b1, k);
    waitCyc(k + 10);
    setAux(1'b0, k);
    waitCyc(k + 10);
    check("R9", auxSeen - auxBefore, 0, "no auxIrq in delay mode");
    check("R9", count, 185, "count untouched in delay mode stop");

    done = 1'b1;
    check("R4", tmoQ.size(), 0, "pending timeouts");
    check("R9", auxQ.size(), 0, "pending aux strobes");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule